// File: doc/BRIEF.md
# RSSI Energy Busy Detector

This block watches received-signal-strength samples from up to four radio channels and decides whether the medium is busy. Each channel keeps a short history of its samples and averages it over a window whose length is programmable. The channels that are not masked off are then compared with two levels: a busy level that must be exceeded, and a lower idle level that must be undercut. The gap between the two levels gives hysteresis in level.

A separate pair of durations gives hysteresis in time. The block declares the medium busy only after the energy has stayed above the busy level for a programmed number of consecutive samples. It returns to idle, and so re-arms, only after every unmasked channel has stayed below the idle level for its own programmed number of consecutive samples. A one-clock detection strobe marks each idle-to-busy change, and a level output shows the current busy state.

Three 32-bit configuration words come in on ports. They carry a synchronous clear, the channel masks, both levels, both durations and the window length. The sample source and the register file that holds these words sit outside the block.

Top module: `energy_busy_detector`

## Requirements
- R1: While rst_n is low, busy and det_pulse are 0 at once, and the per-channel sample histories are cleared to zero.
- R2: Channel k takes its sample from rssi_bus[k*10 +: 10], with channel A as k=0. Its average is the sum of its last N accepted samples divided by N. N is dur_word[20:16], and a value of 0 is used as 1. History that has not yet been filled counts as zero.
- R3: While idle, busy rises when at least one unmasked channel's average is strictly greater than thr_word[31:16] for busy-duration consecutive accepted samples. The busy duration is dur_word[15:8], and 0 is used as 1.
- R4: An accepted sample for which no unmasked channel is above the busy level restarts the busy count from zero.
- R5: det_pulse is high for exactly one clock, in the same cycle in which busy first reads 1 after being 0, and at no other time.
- R6: While busy, busy falls when every unmasked channel's average is strictly below thr_word[15:0] for idle-duration consecutive accepted samples. The idle duration is dur_word[7:0], and 0 is used as 1. Any accepted sample that fails this test restarts the count.
- R7: Setting cfg_word[k] excludes channel k from both the busy test and the idle test. A masked channel still records its samples, so its history is current when the mask bit is cleared.
- R8: A sample is accepted on a rising edge where sample_valid is 1. Its effect on busy and det_pulse appears after the next rising edge. Without accepted samples, busy holds its value.
- R9: While cfg_word[31] is 1, the block clears its histories, counts and busy state. It accepts no samples and holds det_pulse at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| sample_valid | input | 1 | A new sample set is present on rssi_bus |
| rssi_bus | input | 40 | Four 10-bit unsigned signal-strength samples, channel A in the low bits |
| cfg_word | input | 32 | Bit 31 is the synchronous clear; bits 3:0 are the channel masks |
| thr_word | input | 32 | Busy level in bits 31:16, idle level in bits 15:0 |
| dur_word | input | 32 | Window length in 20:16, busy duration in 15:8, idle duration in 7:0 |
| busy | output | 1 | Medium is currently judged busy |
| det_pulse | output | 1 | One-clock strobe on each idle-to-busy change |

## Verification
The bench puts averages exactly on the busy level, where a design that compares with greater-or-equal would declare busy early. It breaks a run of high samples partway through, where a count that does not restart would fire one sample too soon. It loads window length 0, where a design that divides by zero or never fires would stay idle, and window length 31, where a history one entry short would never reach the level. It feeds large samples while the clear bit is set and while a channel is masked, where a design that shifts history during clear would detect on the first sample after release, and a design that ignores the mask would raise busy or hold it.

// File: rtl/edet_pkg.sv
package edet_pkg;
  localparam int WORD_W       = 32;
  localparam int CFG_CLR_BIT  = 31;
  localparam int THR_W        = 16;
  localparam int THR_BUSY_LSB = 16;
  localparam int THR_IDLE_LSB = 0;
  localparam int LEN_W        = 5;
  localparam int DUR_W        = 8;
  localparam int DUR_LEN_LSB  = 16;
  localparam int DUR_BUSY_LSB = 8;
  localparam int DUR_IDLE_LSB = 0;

  typedef enum logic {ST_IDLE = 1'b0, ST_BUSY = 1'b1} det_state_e;

  // A zero field stands for one.
  function automatic logic [DUR_W:0] dur_target(input logic [DUR_W-1:0] raw);
    return (raw == '0) ? (DUR_W+1)'(1) : {1'b0, raw};
  endfunction
endpackage

// File: rtl/edet_chan.sv
module edet_chan
  import edet_pkg::*;
#(
  parameter int SW = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic [SW-1:0]    sample,
  input  logic [LEN_W-1:0] win_len,
  input  logic [THR_W-1:0] thr_busy,
  input  logic [THR_W-1:0] thr_idle,
  output logic             above,
  output logic             below
);
  localparam int DEPTH = (1 << LEN_W) - 1;
  localparam int SUM_W = SW + LEN_W;
  localparam int LIM_W = THR_W + LEN_W;
  localparam int CMP_W = (SUM_W > LIM_W) ? SUM_W : LIM_W;

  logic [SW-1:0]    hist_q [DEPTH];
  logic [SW-1:0]    hist_d [DEPTH];
  logic [CMP_W-1:0] sum;
  logic [CMP_W-1:0] lim_busy;
  logic [CMP_W-1:0] lim_idle;

  // next-state of the sample history
  always_comb begin
    for (int i = 0; i < DEPTH; i++) begin
      if (clr) begin
        hist_d[i] = '0;
      end else if (shift_en) begin
        hist_d[i] = (i == 0) ? sample : hist_q[(i == 0) ? 0 : i-1];
      end else begin
        hist_d[i] = hist_q[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) hist_q[i] <= hist_d[i];
    end
  end

  // windowed sum over the newest win_len entries
  always_comb begin
    sum = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (LEN_W'(i) < win_len) sum = sum + CMP_W'(hist_q[i]);
    end
  end

  // average vs level, compared as sum vs level * length
  assign lim_busy = CMP_W'(thr_busy) * CMP_W'(win_len);
  assign lim_idle = CMP_W'(thr_idle) * CMP_W'(win_len);
  assign above    = sum > lim_busy;
  assign below    = sum < lim_idle;

  // R1
  clr_hist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (sum == '0));
endmodule

// File: rtl/edet_fsm.sv
module edet_fsm
  import edet_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             eval_en,
  input  logic             hi_any,
  input  logic             lo_all,
  input  logic [DUR_W-1:0] busy_dur,
  input  logic [DUR_W-1:0] idle_dur,
  output logic             busy,
  output logic             det_pulse
);
  det_state_e       st_q, st_d;
  logic [DUR_W-1:0] cnt_q, cnt_d;
  logic             pulse_q, pulse_d;
  logic [DUR_W:0]   cnt_inc;
  logic [DUR_W:0]   busy_tgt;
  logic [DUR_W:0]   idle_tgt;

  assign cnt_inc  = {1'b0, cnt_q} + (DUR_W+1)'(1);
  assign busy_tgt = dur_target(busy_dur);
  assign idle_tgt = dur_target(idle_dur);

  always_comb begin
    st_d    = st_q;
    cnt_d   = cnt_q;
    pulse_d = 1'b0;
    if (clr) begin
      st_d  = ST_IDLE;
      cnt_d = '0;
    end else if (eval_en) begin
      unique case (st_q)
        ST_IDLE: begin
          if (!hi_any) begin
            cnt_d = '0;
          end else if (cnt_inc >= busy_tgt) begin
            st_d    = ST_BUSY;
            cnt_d   = '0;
            pulse_d = 1'b1;
          end else begin
            cnt_d = cnt_inc[DUR_W-1:0];
          end
        end
        ST_BUSY: begin
          if (!lo_all) begin
            cnt_d = '0;
          end else if (cnt_inc >= idle_tgt) begin
            st_d  = ST_IDLE;
            cnt_d = '0;
          end else begin
            cnt_d = cnt_inc[DUR_W-1:0];
          end
        end
        default: st_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      cnt_q   <= cnt_d;
      pulse_q <= pulse_d;
    end
  end

  assign busy      = (st_q == ST_BUSY);
  assign det_pulse = pulse_q;

  // R5
  pulse_on_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |-> $rose(busy));
  // R5
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    det_pulse |=> !det_pulse);
  // R3
  rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(hi_any && eval_en && !clr));
  // R6
  fall_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(clr || (eval_en && lo_all)));
  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!eval_en && !clr) |=> $stable(busy));
  // R9
  clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!busy && !det_pulse));
endmodule

// File: rtl/energy_busy_detector.sv
module energy_busy_detector
  import edet_pkg::*;
#(
  parameter int NCH = 4,
  parameter int SW  = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sample_valid,
  input  logic [NCH*SW-1:0] rssi_bus,
  input  logic [WORD_W-1:0] cfg_word,
  input  logic [WORD_W-1:0] thr_word,
  input  logic [WORD_W-1:0] dur_word,
  output logic              busy,
  output logic              det_pulse
);
  localparam int DUR_TOP = DUR_LEN_LSB + LEN_W;

  logic             clr;
  logic [NCH-1:0]   mask;
  logic [THR_W-1:0] thr_busy, thr_idle;
  logic [LEN_W-1:0] len_raw, win_len;
  logic [DUR_W-1:0] busy_dur, idle_dur;
  logic             shift_en;
  logic             eval_q, eval_d;
  logic [NCH-1:0]   above, below;
  logic             hi_any, lo_all;
  logic             unused_cfg_bits;

  assign clr      = cfg_word[CFG_CLR_BIT];
  assign mask     = cfg_word[NCH-1:0];
  assign thr_busy = thr_word[THR_BUSY_LSB +: THR_W];
  assign thr_idle = thr_word[THR_IDLE_LSB +: THR_W];
  assign len_raw  = dur_word[DUR_LEN_LSB +: LEN_W];
  assign win_len  = (len_raw == '0) ? LEN_W'(1) : len_raw;
  assign busy_dur = dur_word[DUR_BUSY_LSB +: DUR_W];
  assign idle_dur = dur_word[DUR_IDLE_LSB +: DUR_W];
  assign unused_cfg_bits = ^{cfg_word[CFG_CLR_BIT-1:NCH], dur_word[WORD_W-1:DUR_TOP]};

  // accept stage: history shifts now, decision one edge later
  assign shift_en = sample_valid & ~clr;
  assign eval_d   = shift_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) eval_q <= 1'b0;
    else        eval_q <= eval_d;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chan
    edet_chan #(.SW(SW)) u_chan (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (clr),
      .shift_en (shift_en),
      .sample   (rssi_bus[k*SW +: SW]),
      .win_len  (win_len),
      .thr_busy (thr_busy),
      .thr_idle (thr_idle),
      .above    (above[k]),
      .below    (below[k])
    );
  end

  assign hi_any = |(above & ~mask);
  assign lo_all = &(below | mask);

  edet_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (clr),
    .eval_en   (eval_q),
    .hi_any    (hi_any),
    .lo_all    (lo_all),
    .busy_dur  (busy_dur),
    .idle_dur  (idle_dur),
    .busy      (busy),
    .det_pulse (det_pulse)
  );

  // R7
  masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_q && !clr && !busy && ((above & ~mask) == '0)) |=> !det_pulse);
endmodule

// File: tb/sim_energy_busy_detector.sv
module sim_energy_busy_detector;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        sample_valid;
  logic [39:0] rssi_bus;
  logic [31:0] cfg_word, thr_word, dur_word;
  logic        busy, det_pulse;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  energy_busy_detector u0 (
    .clk(clk), .rst_n(rst_n), .sample_valid(sample_valid), .rssi_bus(rssi_bus),
    .cfg_word(cfg_word), .thr_word(thr_word), .dur_word(dur_word),
    .busy(busy), .det_pulse(det_pulse)
  );

  typedef struct packed {
    logic [9:0] a;
    logic [9:0] b;
    logic       exp_busy;
    logic       exp_pulse;
  } vec_t;

  // window 2, busy level 100 (sum > 200), idle level 50 (sum < 100), durations 2
  localparam vec_t TBL [15] = '{
    '{10'd150, 10'd0,   1'b0, 1'b0},
    '{10'd150, 10'd0,   1'b0, 1'b0},
    '{10'd50,  10'd0,   1'b0, 1'b0},
    '{10'd300, 10'd0,   1'b0, 1'b0},
    '{10'd300, 10'd0,   1'b1, 1'b1},
    '{10'd300, 10'd0,   1'b1, 1'b0},
    '{10'd0,   10'd0,   1'b1, 1'b0},
    '{10'd0,   10'd0,   1'b1, 1'b0},
    '{10'd0,   10'd250, 1'b1, 1'b0},
    '{10'd0,   10'd0,   1'b1, 1'b0},
    '{10'd0,   10'd0,   1'b1, 1'b0},
    '{10'd0,   10'd0,   1'b0, 1'b0},
    '{10'd0,   10'd120, 1'b0, 1'b0},
    '{10'd0,   10'd120, 1'b0, 1'b0},
    '{10'd0,   10'd120, 1'b1, 1'b1}
  };

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  // drive one sample; returns just after the edge where its effect shows
  task automatic send(input logic [9:0] a, input logic [9:0] b,
                      input logic [9:0] c, input logic [9:0] d);
    @(negedge clk);
    sample_valid = 1'b1;
    rssi_bus     = {d, c, b, a};
    @(posedge clk);
    @(negedge clk);
    sample_valid = 1'b0;
    @(posedge clk);
    #1;
  endtask

  task automatic pulse_clr();
    @(negedge clk);
    cfg_word[31] = 1'b1;
    repeat (2) @(negedge clk);
    cfg_word[31] = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; sample_valid = 1'b0; rssi_bus = '0;
    cfg_word = 32'h0;
    thr_word = {16'd100, 16'd50};
    dur_word = {11'd0, 5'd2, 8'd2, 8'd2};
    repeat (3) @(posedge clk);
    #1;
    check("R1 busy in reset", busy, 0);
    check("R1 pulse in reset", det_pulse, 0);
    @(negedge clk) rst_n = 1'b1;

    // vector table: R3 R4 R6 R5
    for (int i = 0; i < 15; i++) begin
      send(TBL[i].a, TBL[i].b, 10'd0, 10'd0);
      check($sformatf("R3_R4_R6 busy vec %0d", i), busy, TBL[i].exp_busy);
      check($sformatf("R5 pulse vec %0d", i), det_pulse, TBL[i].exp_pulse);
    end

    // R5: strobe gone one clock later
    @(posedge clk); #1;
    check("R5 strobe one clock", det_pulse, 0);

    // R8: zero data without valid must not move busy
    @(negedge clk) rssi_bus = '0;
    repeat (6) @(posedge clk);
    #1;
    check("R8 hold without valid", busy, 1);

    // R1: asynchronous reset clears at once
    @(negedge clk) rst_n = 1'b0;
    #1;
    check("R1 async clear", busy, 0);
    @(negedge clk) rst_n = 1'b1;

    // R9: samples ignored while clear bit is set
    dur_word = {11'd0, 5'd2, 8'd1, 8'd2};
    @(negedge clk) cfg_word = 32'h8000_0000;
    send(10'd1000, 10'd1000, 10'd1000, 10'd1000);
    check("R9 busy under clear", busy, 0);
    check("R9 pulse under clear", det_pulse, 0);
    send(10'd1000, 10'd1000, 10'd1000, 10'd1000);
    check("R9 busy under clear 2", busy, 0);
    @(negedge clk) cfg_word = 32'h0;
    send(10'd150, 10'd0, 10'd0, 10'd0);
    check("R9 history empty after clear", busy, 0);
    send(10'd150, 10'd0, 10'd0, 10'd0);
    check("R3 busy duration one", busy, 1);
    check("R5 pulse duration one", det_pulse, 1);

    // R7: masked channel cannot raise busy, but keeps its history
    pulse_clr();
    @(negedge clk) cfg_word = 32'h0000_0001;
    send(10'd1000, 10'd0, 10'd0, 10'd0);
    send(10'd1000, 10'd0, 10'd0, 10'd0);
    check("R7 masked high channel", busy, 0);
    @(negedge clk) cfg_word = 32'h0;
    send(10'd0, 10'd0, 10'd0, 10'd0);
    check("R7 unmasked history counts", busy, 1);

    // R7 + R6: masked channel ignored in idle test, idle duration 0 as 1
    @(negedge clk) begin cfg_word = 32'h0000_0001; dur_word = {11'd0, 5'd2, 8'd1, 8'd0}; end
    send(10'd1000, 10'd0, 10'd0, 10'd0);
    check("R7_R6 masked channel released", busy, 0);

    // R2: window 0 used as 1, strict level
    pulse_clr();
    @(negedge clk) begin cfg_word = 32'h0; dur_word = {11'd0, 5'd0, 8'd1, 8'd1}; end
    send(10'd0, 10'd0, 10'd0, 10'd100);
    check("R2 window zero at level", busy, 0);
    send(10'd0, 10'd0, 10'd0, 10'd101);
    check("R2 window zero above level", busy, 1);

    // R2: full 31-entry window
    pulse_clr();
    @(negedge clk) begin thr_word = {16'd10, 16'd5}; dur_word = {11'd0, 5'd31, 8'd1, 8'd1}; end
    for (int i = 0; i < 31; i++) send(10'd0, 10'd0, 10'd10, 10'd0);
    check("R2 window 31 at level", busy, 0);
    send(10'd0, 10'd0, 10'd11, 10'd0);
    check("R2 window 31 above level", busy, 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R8 watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule